// File: doc/BRIEF.md
# Tape Read Format Checker

This block sits behind the read path of a nine- or seven-channel tape unit. It takes one recovered character per character time and turns the stream into strobed data for a tape controller. Each character is nine bits: bit 8 is the vertical parity channel and bits 7:0 are the data channels. A free-running character-time tick marks every slot on tape. A valid flag given with the tick says that the slot held a character; a tick without it is an empty slot. Whether a character is data or part of the record trailer is worked out only from the empty slots around it. There is no framing signal on the input.

The controller starts each operation with a one-cycle start pulse. The pulse latches the direction, the track mode and the requested parity. In forward motion the block checks vertical parity, builds the cyclic check character over the data and keeps a running longitudinal XOR of every character. It then flags the check trailer and the longitudinal trailer as they arrive. In reverse motion it only passes characters through. After the record it issues synthetic trailer strobes, so the controller always sees a record end the same way. Single-character end-of-file records are recognised in both directions and confirmed only after a run of empty slots.

Top module: `rdfmt_checker`

## Requirements
- R1: After reset every output is zero, and characters presented before the first start pulse produce no strobe.
- R2: A data character accepted on a tick produces a one-cycle `rd_stb` in the cycle after that tick, with `rd_data` equal to the character and all three identification flags low.
- R3: In forward motion each data character is checked for vertical parity over all nine bits. Nine-track needs an odd count of ones, whatever `op_even` says. Seven-track needs odd when `op_even`=0 and even when it is 1. A failure sets `vpe_err`, which stays set until the next start. Parity is never checked in reverse motion.
- R4: Nine-track forward check character. The register starts at zero. For each data character it is XORed with the character, then rotated: the new bit 0 takes bit 8, bits 7:1 take bits 6:0, and bit 8 takes bit 7. If the bit moved into bit 8 is 1, new bits 5:2 are inverted. The expected character is the register XOR 9'h1EB. The first character that follows data after 4 or more empty ticks is strobed with `crc_id`. `crc_err` is set when that character differs from the expected one.
- R5: Every character accepted in a record, trailers included, is XORed into a nine-bit longitudinal register. The forward longitudinal trailer is strobed with `lrc_id`. `lrc_err` is set when the register, including that trailer, is not zero.
- R6: From the first tick after a forward longitudinal strobe, `rd_data` shows the longitudinal register: a 1 in each failing channel. It keeps showing it until the next start.
- R7: In seven-track forward motion the first trailer character is the longitudinal trailer, and `crc_id` is never raised.
- R8: In reverse motion every character is strobed with no flags. On the 5th empty tick after the last character, a nine-track record gets a strobe with `crc_id`, and the next tick brings a strobe with `lrc_id`. A seven-track record gets only the `lrc_id` strobe, on that 5th tick. Synthetic strobes carry the longitudinal register on `rd_data`.
- R9: File mark, in either direction. The record's first character has bits 7:0 equal to 8'h13 (nine-track) or 8'h0F (seven-track), and a second character follows after 1 to 3 empty ticks. The second character gives no strobe. On the 5th empty tick after it, a strobe is issued with `lrc_id` and `fmk_id` both set.
- R10: `rd_data` and the identification flags hold their values in the cycle after a strobe. They change only on a tick or a start.
- R11: Once the final strobe of a record has been issued, further characters produce no strobe until the next start.
- R12: A start pulse clears `rd_data`, all flags and all error bits, and latches direction, track mode and parity for the new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse that begins an operation |
| op_rev | input | 1 | 1 = reverse motion, latched at start |
| op_7trk | input | 1 | 1 = seven-track format, latched at start |
| op_even | input | 1 | Even parity requested (seven-track only), latched at start |
| chr_tick | input | 1 | One character time elapsed (at most one cycle in two) |
| chr_vld | input | 1 | A character is present in this slot, sampled with `chr_tick` |
| chr_data | input | 9 | Character read, bit 8 = parity channel |
| rd_data | output | 9 | Strobed character, or the longitudinal register after the record |
| rd_stb | output | 1 | One-cycle read strobe |
| crc_id | output | 1 | Strobe is for the check character |
| lrc_id | output | 1 | Strobe is for the longitudinal character (record end) |
| fmk_id | output | 1 | Record was a file mark |
| vpe_err | output | 1 | Vertical parity error seen in this operation |
| crc_err | output | 1 | Check character mismatch |
| lrc_err | output | 1 | Longitudinal mismatch |

## Verification
The in-RTL assertions check the rules that must hold on every cycle. A strobe only ever follows a tick. Data and flags hold in the cycle after a strobe. The check and longitudinal flags are never both set, and a file mark always comes with the longitudinal flag. No parity error appears in reverse, no check flag appears in seven-track, a finished record stays silent, and the gap counter stays in bounds. Only the bench's scenarios show the parts that depend on content and order. These are the check-character arithmetic, which trailer gets which flag after a given gap pattern, the exact tick of the synthetic and file-mark strobes, and the failing-channel pattern shown after an erroneous record.

// File: rtl/rdfmt_pkg.sv
// Shared types and pure functions for the tape read format checker.
// Assumes a nine-bit character: bit 8 parity channel, bits 7:0 data channels.
package rdfmt_pkg;
    localparam int CH_W = 9;
    typedef logic [CH_W-1:0] chr_t;

    typedef enum logic [2:0] {
        ST_OFF,   // no operation started yet
        ST_RUN,   // receiving characters of a record
        ST_FMK,   // file-mark trailer seen, waiting for confirmation gap
        ST_REVL,  // reverse nine-track: synthetic longitudinal strobe due
        ST_DONE   // record finished, input ignored
    } st_t;

    // channels left untouched when the check register is emitted: 2 and 4
    localparam chr_t CRC_OUT_MASK = 9'h1EB;

    // One check-register update for a data character.
    function automatic chr_t crc_next(chr_t acc, chr_t c);
        chr_t x;
        chr_t y;
        x = acc ^ c;
        y = {x[7], x[6:0], x[8]};
        if (x[7]) y[5:2] = ~y[5:2];
        return y;
    endfunction

    // Vertical parity rule: nine-track always odd, seven-track selectable.
    function automatic logic parity_ok(chr_t c, logic seven, logic even);
        if (!seven) return ^c;
        return (^c) ^ even;
    endfunction
endpackage

// File: rtl/rdfmt_gap_cnt.sv
// Counts empty character slots since the last character, saturating at MAXV.
// Assumes clr has priority and a character always restarts the count at zero.
module rdfmt_gap_cnt #(
    parameter int MAXV = 5,
    localparam int W = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hit,
    input  logic         idle,
    output logic [W-1:0] gap
);
    logic [W-1:0] gap_q;

    // saturating empty-slot counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr || hit) gap_q <= '0;
        else if (idle && gap_q != W'(MAXV)) gap_q <= gap_q + 1'b1;
    end

    assign gap = gap_q;

    a_r8_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= W'(MAXV));
endmodule

// File: rtl/rdfmt_crc_acc.sv
// Accumulates the nine-track check character over forward data characters.
// Assumes step is only raised for data characters of a forward nine-track record.
module rdfmt_crc_acc
    import rdfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  chr_t chr,
    output chr_t expect_chr
);
    chr_t acc_q;

    // check register update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (step) acc_q <= crc_next(acc_q, chr);
    end

    assign expect_chr = acc_q ^ CRC_OUT_MASK;

    a_r4_crc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> expect_chr == CRC_OUT_MASK);
endmodule

// File: rtl/rdfmt_lrc_acc.sv
// Longitudinal XOR register: every accepted character is folded in per channel.
// Assumes clr starts each operation; acc marks accepted characters only.
module rdfmt_lrc_acc
    import rdfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic acc,
    input  chr_t chr,
    output chr_t lrc
);
    chr_t lrc_q;

    // per-channel XOR accumulation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) lrc_q <= '0;
        else if (acc) lrc_q <= lrc_q ^ chr;
    end

    assign lrc = lrc_q;

    a_r5_lrc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc) |=> $stable(lrc_q));
endmodule

// File: rtl/rdfmt_checker.sv
// Tape read format checker: classifies characters by the empty slots around
// them, checks parity, check and longitudinal characters, recognises file
// marks and issues forward or reverse status strobes.
// Assumes chr_tick is never high in two consecutive cycles.
module rdfmt_checker
    import rdfmt_pkg::*;
#(
    parameter int         TRL_GAP = 4,
    parameter int         END_GAP = 5,
    parameter logic [7:0] EOF9    = 8'h13,
    parameter logic [7:0] EOF7    = 8'h0F,
    localparam int        GW      = $clog2(END_GAP + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic       op_rev,
    input  logic       op_7trk,
    input  logic       op_even,
    input  logic       chr_tick,
    input  logic       chr_vld,
    input  logic [8:0] chr_data,
    output logic [8:0] rd_data,
    output logic       rd_stb,
    output logic       crc_id,
    output logic       lrc_id,
    output logic       fmk_id,
    output logic       vpe_err,
    output logic       crc_err,
    output logic       lrc_err
);
    st_t        state_q;
    logic       rev_q, m7_q, even_q;
    logic [1:0] n_q;
    logic       trl_q, eof1_q;
    logic [GW-1:0] gap;
    chr_t       crc_exp, lrc_q;

    logic ev_chr, ev_idle, in_run;
    logic is_fm2, is_trl, is_dat, is_crc_trl, is_lrc_trl;
    logic rev_end, fmk_end;
    logic [7:0] eof_code;
    chr_t lrc_next;

    assign ev_chr  = chr_tick & chr_vld;
    assign ev_idle = chr_tick & ~chr_vld;
    assign in_run  = (state_q == ST_RUN);

    // character classification from the gap structure
    always_comb begin
        eof_code   = m7_q ? EOF7 : EOF9;
        lrc_next   = lrc_q ^ chr_data;
        is_fm2     = in_run && ev_chr && n_q == 2'd1 && eof1_q &&
                     gap >= GW'(1) && gap < GW'(TRL_GAP);
        is_trl     = in_run && ev_chr && !rev_q && !is_fm2 && n_q != 2'd0 &&
                     (gap >= GW'(TRL_GAP) || trl_q);
        is_dat     = in_run && ev_chr && !is_fm2 && !is_trl;
        is_crc_trl = is_trl && !m7_q && !trl_q;
        is_lrc_trl = is_trl && !is_crc_trl;
        rev_end    = in_run && rev_q && ev_idle && n_q != 2'd0 &&
                     gap == GW'(END_GAP - 1);
        fmk_end    = (state_q == ST_FMK) && ev_idle && gap == GW'(END_GAP - 1);
    end

    rdfmt_gap_cnt #(.MAXV(END_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(op_start),
        .hit(ev_chr), .idle(ev_idle), .gap(gap)
    );

    rdfmt_crc_acc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(op_start),
        .step(is_dat && !rev_q && !m7_q), .chr(chr_data), .expect_chr(crc_exp)
    );

    rdfmt_lrc_acc u_lrc (
        .clk(clk), .rst_n(rst_n), .clr(op_start),
        .acc(in_run && ev_chr), .chr(chr_data), .lrc(lrc_q)
    );

    // sequencing and registered controller-side outputs
    always_ff @(posedge clk) begin
        rd_stb <= 1'b0;
        if (!rst_n) begin
            state_q <= ST_OFF;
            {rev_q, m7_q, even_q, trl_q, eof1_q} <= '0;
            n_q     <= '0;
            rd_data <= '0;
            {crc_id, lrc_id, fmk_id, vpe_err, crc_err, lrc_err} <= '0;
        end else if (op_start) begin
            state_q <= ST_RUN;
            rev_q   <= op_rev;
            m7_q    <= op_7trk;
            even_q  <= op_even;
            {trl_q, eof1_q} <= '0;
            n_q     <= '0;
            rd_data <= '0;
            {crc_id, lrc_id, fmk_id, vpe_err, crc_err, lrc_err} <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (ev_chr) begin
                        if (n_q != 2'd3) n_q <= n_q + 2'd1;
                        if (n_q == 2'd0) eof1_q <= (chr_data[7:0] == eof_code);
                        if (is_fm2) begin
                            state_q <= ST_FMK;
                        end else if (is_dat) begin
                            rd_stb  <= 1'b1;
                            rd_data <= chr_data;
                            {crc_id, lrc_id, fmk_id} <= '0;
                            if (!rev_q && !parity_ok(chr_data, m7_q, even_q))
                                vpe_err <= 1'b1;
                        end else if (is_crc_trl) begin
                            rd_stb  <= 1'b1;
                            rd_data <= chr_data;
                            {crc_id, lrc_id, fmk_id} <= 3'b100;
                            trl_q   <= 1'b1;
                            if (chr_data != crc_exp) crc_err <= 1'b1;
                        end else if (is_lrc_trl) begin
                            rd_stb  <= 1'b1;
                            rd_data <= chr_data;
                            {crc_id, lrc_id, fmk_id} <= 3'b010;
                            lrc_err <= (lrc_next != '0);
                            state_q <= ST_DONE;
                        end
                    end else if (rev_end) begin
                        rd_stb  <= 1'b1;
                        rd_data <= lrc_q;
                        if (!m7_q) begin
                            {crc_id, lrc_id, fmk_id} <= 3'b100;
                            state_q <= ST_REVL;
                        end else begin
                            {crc_id, lrc_id, fmk_id} <= 3'b010;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_REVL: begin
                    if (chr_tick) begin
                        rd_stb  <= 1'b1;
                        rd_data <= lrc_q;
                        {crc_id, lrc_id, fmk_id} <= 3'b010;
                        state_q <= ST_DONE;
                    end
                end
                ST_FMK: begin
                    if (fmk_end) begin
                        rd_stb  <= 1'b1;
                        rd_data <= lrc_q;
                        {crc_id, lrc_id, fmk_id} <= 3'b011;
                        lrc_err <= (lrc_q != '0);
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (chr_tick) rd_data <= lrc_q;
                end
                default: ;
            endcase
        end
    end

    a_r2_stb_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(chr_tick));
    a_r10_hold_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !chr_tick && !op_start) |=>
        ($stable(rd_data) && $stable(crc_id) && $stable(lrc_id) && $stable(fmk_id)));
    a_r3_no_vpe_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        rev_q |-> !vpe_err);
    a_r7_no_crc_seven: assert property (@(posedge clk) disable iff (!rst_n)
        m7_q |-> !crc_id);
    a_r9_fmk_with_lrc: assert property (@(posedge clk) disable iff (!rst_n)
        fmk_id |-> lrc_id);
    a_r4_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_id && lrc_id));
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !op_start) |=> !rd_stb);
endmodule

// File: tb/rdfmt_checker_test.sv
module rdfmt_checker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, op_rev = 1'b0, op_7trk = 1'b0, op_even = 1'b0;
    logic chr_tick = 1'b0, chr_vld = 1'b0;
    logic [8:0] chr_data = '0;
    logic [8:0] rd_data;
    logic rd_stb, crc_id, lrc_id, fmk_id, vpe_err, crc_err, lrc_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic       c_stb, c_crc, c_lrc, c_fmk, c_vpe, c_crce, c_lrce, h_stb;
    logic [8:0] c_data, h_data;

    always #2 clk = ~clk;

    rdfmt_checker uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_rev(op_rev),
        .op_7trk(op_7trk), .op_even(op_even), .chr_tick(chr_tick),
        .chr_vld(chr_vld), .chr_data(chr_data), .rd_data(rd_data),
        .rd_stb(rd_stb), .crc_id(crc_id), .lrc_id(lrc_id), .fmk_id(fmk_id),
        .vpe_err(vpe_err), .crc_err(crc_err), .lrc_err(lrc_err)
    );

    task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one character slot; outputs captured one edge after the tick
    task automatic ev(input logic v, input logic [8:0] c);
        @(negedge clk);
        chr_tick = 1'b1; chr_vld = v; chr_data = c;
        @(negedge clk);
        chr_tick = 1'b0; chr_vld = 1'b0;
        c_stb = rd_stb; c_data = rd_data; c_crc = crc_id; c_lrc = lrc_id;
        c_fmk = fmk_id; c_vpe = vpe_err; c_crce = crc_err; c_lrce = lrc_err;
        @(negedge clk);
        h_stb = rd_stb; h_data = rd_data;
        @(negedge clk);
    endtask

    task automatic idles(input int n);
        for (int i = 0; i < n; i++) ev(1'b0, '0);
    endtask

    task automatic start(input logic rev, input logic m7, input logic ev_par);
        @(negedge clk);
        op_start = 1'b1; op_rev = rev; op_7trk = m7; op_even = ev_par;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    function automatic logic [8:0] podd(input logic [7:0] d);
        return {~^d, d};
    endfunction

    function automatic logic [8:0] crc_upd(input logic [8:0] a, input logic [8:0] c);
        logic [8:0] x, y;
        x = a ^ c;
        y = {x[7], x[6:0], x[8]};
        if (x[7]) y = y ^ 9'h03C;
        return y;
    endfunction

    // {seven, even, expected vpe, char}
    localparam logic [11:0] VEC [9] = '{
        {1'b0, 1'b0, 1'b0, 9'h001},
        {1'b0, 1'b0, 1'b1, 9'h003},
        {1'b0, 1'b0, 1'b1, 9'h113},
        {1'b0, 1'b1, 1'b0, 9'h001},
        {1'b0, 1'b1, 1'b1, 9'h000},
        {1'b1, 1'b0, 1'b0, 9'h007},
        {1'b1, 1'b0, 1'b1, 9'h00F},
        {1'b1, 1'b1, 1'b0, 9'h003},
        {1'b1, 1'b1, 1'b1, 9'h001}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] d0, d1, d2, crc_c, lrc_c, acc, bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and no activity before a start
        chk("R1 reset outputs", {rd_stb, crc_id, lrc_id, fmk_id, vpe_err, crc_err, lrc_err, 2'b00}, '0);
        chk("R1 reset data", rd_data, '0);
        ev(1'b1, 9'h041);
        chk("R1 no strobe before start", {8'h0, c_stb}, '0);

        // R2 / R3 vector table
        for (int i = 0; i < 9; i++) begin
            start(1'b0, VEC[i][11], VEC[i][10]);
            ev(1'b1, VEC[i][8:0]);
            chk("R2 data strobe", {8'h0, c_stb}, 9'h1);
            chk("R2 data value", c_data, VEC[i][8:0]);
            chk("R3 parity flag", {8'h0, c_vpe}, {8'h0, VEC[i][9]});
            chk("R2 flags clear", {6'h0, c_crc, c_lrc, c_fmk}, '0);
        end

        // R4 R5 R6 R10 R11 nine-track forward good record
        start(1'b0, 1'b0, 1'b0);
        d0 = podd(8'h41); d1 = podd(8'h7E); d2 = podd(8'h00);
        acc = crc_upd(crc_upd(crc_upd('0, d0), d1), d2);
        crc_c = acc ^ 9'h1EB;
        lrc_c = d0 ^ d1 ^ d2 ^ crc_c;
        ev(1'b1, d0); ev(1'b1, d1); ev(1'b1, d2);
        idles(4);
        chk("R4 no strobe in gap", {8'h0, c_stb}, '0);
        ev(1'b1, crc_c);
        chk("R4 check strobe", {6'h0, c_stb, c_crc, c_lrc}, 9'h006);
        chk("R4 check value", c_data, crc_c);
        chk("R4 check ok", {8'h0, c_crce}, '0);
        chk("R10 data held", h_data, crc_c);
        chk("R10 strobe single", {8'h0, h_stb}, '0);
        idles(4);
        ev(1'b1, lrc_c);
        chk("R5 lrc strobe", {6'h0, c_stb, c_crc, c_lrc}, 9'h005);
        chk("R5 lrc value", c_data, lrc_c);
        chk("R5 lrc ok", {7'h0, c_lrce, c_vpe}, '0);
        ev(1'b0, '0);
        chk("R6 register shown", c_data, '0);
        ev(1'b1, 9'h123);
        chk("R11 ignored after end", {8'h0, c_stb}, '0);

        // R4 bad check character
        start(1'b0, 1'b0, 1'b0);
        d0 = podd(8'h41);
        crc_c = crc_upd('0, d0) ^ 9'h1EB;
        bad = crc_c ^ 9'h001;
        ev(1'b1, d0);
        idles(4);
        ev(1'b1, bad);
        chk("R4 check error", {7'h0, c_crc, c_crce}, 9'h003);
        idles(5);
        ev(1'b1, d0 ^ bad);
        chk("R5 lrc after bad check", {7'h0, c_lrc, c_lrce}, 9'h002);

        // R7 R5 R6 seven-track forward, bad longitudinal
        start(1'b0, 1'b1, 1'b1);
        ev(1'b1, 9'h003); ev(1'b1, 9'h005);
        idles(4);
        ev(1'b1, 9'h003 ^ 9'h005 ^ 9'h005);
        chk("R7 first trailer is lrc", {6'h0, c_stb, c_crc, c_lrc}, 9'h005);
        chk("R5 lrc error", {8'h0, c_lrce}, 9'h001);
        ev(1'b0, '0);
        chk("R6 failing channels", c_data, 9'h005);

        // R12 start clears
        start(1'b0, 1'b0, 1'b0);
        chk("R12 cleared", {rd_stb, crc_id, lrc_id, fmk_id, vpe_err, crc_err, lrc_err, 2'b00}, '0);
        chk("R12 data cleared", rd_data, '0);

        // R8 R3 nine-track reverse
        start(1'b1, 1'b0, 1'b0);
        d0 = 9'h000; d1 = podd(8'h22); d2 = podd(8'h5A);
        crc_c = 9'h0A7; lrc_c = 9'h14C;
        ev(1'b1, lrc_c);
        chk("R8 reverse pass", {6'h0, c_stb, c_crc, c_lrc}, 9'h004);
        idles(4);
        ev(1'b1, crc_c);
        chk("R8 reverse no flag", {6'h0, c_stb, c_crc, c_lrc}, 9'h004);
        idles(4);
        ev(1'b1, d0); ev(1'b1, d1); ev(1'b1, d2);
        chk("R3 no parity in reverse", {8'h0, c_vpe}, '0);
        idles(4);
        chk("R8 quiet before end", {8'h0, c_stb}, '0);
        ev(1'b0, '0);
        chk("R8 synthetic check", {6'h0, c_stb, c_crc, c_lrc}, 9'h006);
        chk("R8 synthetic data", c_data, lrc_c ^ crc_c ^ d0 ^ d1 ^ d2);
        ev(1'b0, '0);
        chk("R8 synthetic lrc", {6'h0, c_stb, c_crc, c_lrc}, 9'h005);
        ev(1'b0, '0);
        chk("R11 quiet after reverse", {8'h0, c_stb}, '0);

        // R8 seven-track reverse
        start(1'b1, 1'b1, 1'b0);
        ev(1'b1, 9'h005); ev(1'b1, 9'h006);
        idles(4);
        chk("R8 seven quiet", {8'h0, c_stb}, '0);
        ev(1'b0, '0);
        chk("R8 seven lrc only", {6'h0, c_stb, c_crc, c_lrc}, 9'h005);
        chk("R8 seven data", c_data, 9'h003);

        // R9 forward nine-track file mark
        start(1'b0, 1'b0, 1'b0);
        ev(1'b1, 9'h013);
        chk("R9 eof passed", c_data, 9'h013);
        idles(3);
        ev(1'b1, 9'h013);
        chk("R9 trailer silent", {8'h0, c_stb}, '0);
        idles(4);
        chk("R9 wait gap", {8'h0, c_stb}, '0);
        ev(1'b0, '0);
        chk("R9 fmk strobe", {5'h0, c_stb, c_crc, c_lrc, c_fmk}, 9'h00B);
        chk("R9 fmk lrc ok", {8'h0, c_lrce}, '0);

        // R9 reverse seven-track file mark
        start(1'b1, 1'b1, 1'b1);
        ev(1'b1, 9'h00F);
        idles(2);
        ev(1'b1, 9'h00F);
        chk("R9 rev trailer silent", {8'h0, c_stb}, '0);
        idles(4);
        ev(1'b0, '0);
        chk("R9 rev fmk strobe", {5'h0, c_stb, c_crc, c_lrc, c_fmk}, 9'h00B);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule